// File: doc/BRIEF.md
# Serial Mode-Register and Readout Slave

This block is a two-wire serial bus slave for a line-data receiver. It accepts one control byte on a bus write and keeps it as the mode register that steers acquisition. On a bus read it streams a block of stored result bytes, most significant bit first, starting with the first byte every time. SDA is open drain: the block only ever pulls it low. SCL is an input only, and the slave never stretches the clock.

One strap pin picks which of two address pairs the slave answers. From the START condition to the STOP condition the block holds a busy flag, and the acquisition side must not write new results while that flag is high. The block also takes its own copy of the result array on every START, so a read always returns one consistent set of bytes. When the master refuses a byte, the block sends a one-cycle pulse that the acquisition side uses to drop its data-valid indication.

SCL and SDA are brought into the system clock domain through a short synchronizer. START and STOP are found as SDA edges while SCL is high.

Top module: `i2cm_mode_slave`

## Requirements
- R1: The slave acknowledges the 8-bit address bytes 0x20 (write) and 0x21 (read) when `sel_i` is low, and 0x22 (write) and 0x23 (read) when `sel_i` is high. Bit 0 of the address byte is the read flag.
- R2: Any other address byte gets no acknowledge. Until the next START, the slave drives nothing on SDA and leaves `mode_o` unchanged.
- R3: In a write, the first byte after the address is acknowledged and appears on `mode_o` once its eighth bit is received. Further bytes before STOP are not acknowledged and have no effect on `mode_o`.
- R4: After reset `mode_o` is 0x00, `busy_o` is low, `sda_oe_o` is low and `valid_clr_o` is low.
- R5: A read returns byte 1 first, taken from `data_i[7:0]`. Byte k is taken from `data_i[8k-1:8k-8]`. Each byte is sent bit 7 first, and each master acknowledge moves the read on to the next byte.
- R6: Reads beyond the last byte (byte 16 by default) return 0xFF, and the byte pointer stays at that position.
- R7: Every START, including a repeated START, resets the byte pointer, so the next read begins again at byte 1.
- R8: A master NACK after a read byte produces exactly one `valid_clr_o` pulse of one cycle. The slave then releases SDA until the next START.
- R9: `busy_o` is high from the detection of a START until the detection of the STOP.
- R10: The result bytes returned in a transaction are those present on `data_i` when its START was detected. Changes to `data_i` after that do not affect them.
- R11: `sda_oe_o` is never asserted while the bus is idle, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Pull SDA low when high (open drain) |
| sel_i | input | 1 | Address pair select strap |
| data_i | input | 128 | Result bytes; byte k at bits 8k-1..8k-8 |
| mode_o | output | 8 | Mode register |
| busy_o | output | 1 | Bus transaction in progress; hold off result updates |
| valid_clr_o | output | 1 | One-cycle pulse on a master NACK; clears data-valid |

## Verification
Each bus line passes through two synchronizer flops and one edge register before the control state changes. A START or STOP therefore shows on `busy_o` on the third rising clock edge after the SDA change, and the per-cycle comparison of `busy_o` against the reference model skips a six-cycle window after each of these events. Slave drive on SDA follows an SCL fall by the same three edges. The bench's bus master holds every SCL phase for eight system clocks, so it samples the acknowledge and data bits mid-high, long after they have settled. `mode_o` and the count of `valid_clr_o` pulses are checked only after STOP, when every update has completed.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK,
        ST_SKIP
    } bus_st_e;

    localparam logic [5:0] ADDR_HI_DEFAULT = 6'b001000;
    localparam logic [7:0] FILL_BYTE       = 8'hFF;

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_chain;
        logic [STAGES-1:0] sda_chain;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.scl_chain = {s_q.scl_chain[STAGES-2:0], scl_i};
        s_d.sda_chain = {s_q.sda_chain[STAGES-2:0], sda_i};
        s_d.scl_prev  = s_q.scl_chain[STAGES-1];
        s_d.sda_prev  = s_q.sda_chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    logic scl_now, sda_now;
    assign scl_now    = s_q.scl_chain[STAGES-1];
    assign sda_now    = s_q.sda_chain[STAGES-1];
    assign scl_s_o    = scl_now;
    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~s_q.scl_prev;
    assign scl_fall_o = ~scl_now & s_q.scl_prev;
    // SDA edge while SCL stayed high
    assign start_o    = scl_now & s_q.scl_prev & s_q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & s_q.scl_prev & ~s_q.sda_prev & sda_now;

endmodule

// File: rtl/i2cm_snapshot.sv
module i2cm_snapshot #(
    parameter int NBYTES = 16,
    parameter int PTR_W  = $clog2(NBYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture_i,
    input  logic [NBYTES*8-1:0] data_i,
    input  logic [PTR_W-1:0]    ptr_i,
    output logic [7:0]          byte_o
);
    import i2cm_pkg::*;

    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [PTR_W-1:0] END_PTR = PTR_W'(NBYTES);

    logic [7:0] snap_d [NBYTES];
    logic [7:0] snap_q [NBYTES];

    always_comb begin
        for (int k = 0; k < NBYTES; k++) begin
            snap_d[k] = capture_i ? data_i[k*8 +: 8] : snap_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NBYTES; k++) snap_q[k] <= '0;
        end else begin
            for (int k = 0; k < NBYTES; k++) snap_q[k] <= snap_d[k];
        end
    end

    always_comb begin
        if (ptr_i < END_PTR) begin
            byte_o = snap_q[ptr_i[IDX_W-1:0]];
        end else begin
            byte_o = FILL_BYTE;
        end
    end

endmodule

// File: rtl/i2cm_mode_slave.sv
module i2cm_mode_slave #(
    parameter int          NBYTES      = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [5:0]  ADDR_HI     = i2cm_pkg::ADDR_HI_DEFAULT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic                sel_i,
    input  logic [NBYTES*8-1:0] data_i,
    output logic [7:0]          mode_o,
    output logic                busy_o,
    output logic                valid_clr_o
);
    import i2cm_pkg::*;

    localparam int PTR_W = $clog2(NBYTES + 1);
    localparam logic [PTR_W-1:0] END_PTR = PTR_W'(NBYTES);
    localparam logic [3:0] BITS_FULL = 4'd8;
    localparam logic [3:0] LAST_TX   = 4'd7;

    typedef struct packed {
        bus_st_e          st;
        logic [3:0]       bitcnt;
        logic [7:0]       shr;
        logic             rw;
        logic [PTR_W-1:0] ptr;
        logic [7:0]       mode;
        logic             oe;
        logic             clr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [7:0] rd_byte;

    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s_o   (scl_s),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_p),
        .stop_o    (stop_p)
    );

    i2cm_snapshot #(.NBYTES(NBYTES), .PTR_W(PTR_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture_i(start_p),
        .data_i   (data_i),
        .ptr_i    (c_q.ptr),
        .byte_o   (rd_byte)
    );

    logic scl_unused;
    assign scl_unused = scl_s;

    always_comb begin
        c_d     = c_q;
        c_d.clr = 1'b0;
        if (start_p) begin
            c_d.st     = ST_ADDR;
            c_d.bitcnt = '0;
            c_d.ptr    = '0;
            c_d.oe     = 1'b0;
        end else if (stop_p) begin
            c_d.st = ST_IDLE;
            c_d.oe = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        c_d.shr    = {c_q.shr[6:0], sda_s};
                        c_d.bitcnt = c_q.bitcnt + 4'd1;
                    end else if (scl_fall && c_q.bitcnt == BITS_FULL) begin
                        if (c_q.shr[7:1] == {ADDR_HI, sel_i}) begin
                            c_d.st = ST_AACK;
                            c_d.oe = 1'b1;
                            c_d.rw = c_q.shr[0];
                        end else begin
                            c_d.st = ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        c_d.bitcnt = '0;
                        if (c_q.rw) begin
                            c_d.st  = ST_RBYTE;
                            c_d.shr = rd_byte;
                            c_d.oe  = ~rd_byte[7];
                        end else begin
                            c_d.st = ST_WBYTE;
                            c_d.oe = 1'b0;
                        end
                    end
                end
                ST_WBYTE: begin
                    if (scl_rise) begin
                        c_d.shr    = {c_q.shr[6:0], sda_s};
                        c_d.bitcnt = c_q.bitcnt + 4'd1;
                    end else if (scl_fall && c_q.bitcnt == BITS_FULL) begin
                        c_d.mode = c_q.shr;
                        c_d.oe   = 1'b1;
                        c_d.st   = ST_WACK;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        c_d.oe = 1'b0;
                        c_d.st = ST_SKIP;
                    end
                end
                ST_RBYTE: begin
                    if (scl_fall) begin
                        if (c_q.bitcnt == LAST_TX) begin
                            c_d.oe = 1'b0;
                            c_d.st = ST_RACK;
                        end else begin
                            c_d.bitcnt = c_q.bitcnt + 4'd1;
                            c_d.shr    = {c_q.shr[6:0], 1'b1};
                            c_d.oe     = ~c_q.shr[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            c_d.clr = 1'b1;
                            c_d.st  = ST_SKIP;
                        end else begin
                            c_d.bitcnt = BITS_FULL;
                            if (c_q.ptr < END_PTR) c_d.ptr = c_q.ptr + 1'b1;
                        end
                    end else if (scl_fall && c_q.bitcnt == BITS_FULL) begin
                        c_d.st     = ST_RBYTE;
                        c_d.bitcnt = '0;
                        c_d.shr    = rd_byte;
                        c_d.oe     = ~rd_byte[7];
                    end
                end
                default: begin
                    c_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st     <= ST_IDLE;
            c_q.bitcnt <= '0;
            c_q.shr    <= '0;
            c_q.rw     <= 1'b0;
            c_q.ptr    <= '0;
            c_q.mode   <= '0;
            c_q.oe     <= 1'b0;
            c_q.clr    <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe_o    = c_q.oe;
    assign mode_o      = c_q.mode;
    assign busy_o      = (c_q.st != ST_IDLE);
    assign valid_clr_o = c_q.clr;

endmodule

// File: rtl/i2cm_mode_slave_chk.sv
module i2cm_mode_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [7:0] mode_o,
    input logic       busy_o,
    input logic       valid_clr_o
);

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sda_oe_o) else $error("idle drive"); // R11

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i) else $error("drive edge with scl high"); // R11

    AST_MODE_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> busy_o) else $error("mode change outside txn"); // R3

    AST_CLR_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_clr_o |-> busy_o) else $error("clear outside txn"); // R8

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_clr_o |=> !valid_clr_o) else $error("clear longer than one cycle"); // R8

    AST_CLR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_clr_o |-> !sda_oe_o) else $error("drive after nack"); // R8

endmodule

bind i2cm_mode_slave i2cm_mode_slave_chk u_chk (.*);

// File: tb/test_i2cm_mode_slave.sv
module test_i2cm_mode_slave;
    localparam int NB = 16;
    localparam int Q  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sel = 1'b0;
    logic [NB*8-1:0] data = '0;
    logic sda_oe, busy, vclr;
    logic [7:0] mode;
    wire  sda_bus = m_sda & ~sda_oe;

    i2cm_mode_slave i_i2cm_mode_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .sel_i(sel), .data_i(data), .mode_o(mode),
        .busy_o(busy), .valid_clr_o(vclr)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0, clr_cnt = 0, guard = 0;
    bit exp_busy = 0, run_cmp = 0, done = 0;
    logic [7:0] snap_model [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n && vclr) clr_cnt++;

    // per-cycle comparison against the model's transaction state
    always @(negedge clk) begin
        if (run_cmp) begin
            if (guard > 0) guard--;
            else begin
                chk(busy == exp_busy, "R9 busy", busy, exp_busy);
                if (!exp_busy) chk(!sda_oe, "R11 idle drive", sda_oe, 0);
            end
        end
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        m_sda = 1; wq(); m_scl = 1; wq();
        m_sda = 0; exp_busy = 1; guard = 6;
        snap_model.delete();
        for (int k = 0; k < NB; k++) snap_model.push_back(data[k*8 +: 8]);
        wq(); m_scl = 0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 0; wq(); m_scl = 1; wq();
        m_sda = 1; exp_busy = 0; guard = 6; wq();
    endtask

    task automatic put_bit(input bit b);
        m_sda = b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq();
    endtask

    task automatic get_bit(output bit b);
        m_sda = 1; wq(); m_scl = 1; wq(); b = sda_bus; wq(); m_scl = 0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(output logic [7:0] v, input bit nack);
        for (int i = 7; i >= 0; i--) begin
            bit b;
            get_bit(b);
            v[i] = b;
        end
        put_bit(nack);
    endtask

    function automatic logic [7:0] model_byte(input int idx);
        return (idx < NB) ? snap_model[idx] : 8'hFF;
    endfunction

    initial begin
        repeat (200000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int clr_before;
        repeat (3) @(negedge clk);
        // R4 reset state
        chk(mode == 8'h00, "R4 mode", mode, 8'h00);
        chk(!busy, "R4 busy", busy, 0);
        chk(!sda_oe, "R4 sda", sda_oe, 0);
        chk(!vclr, "R4 clr", vclr, 0);
        rst_n = 1; repeat (4) @(negedge clk);
        run_cmp = 1;

        // R1 + R3: write with sel low
        for (int k = 0; k < NB; k++) data[k*8 +: 8] = 8'((k * 37) + 3);
        sel = 0;
        bus_start();
        put_byte(8'h20, ack); chk(ack == 0, "R1 write addr sel low", ack, 0);
        put_byte(8'hA5, ack); chk(ack == 0, "R3 control ack", ack, 0);
        put_byte(8'h3C, ack); chk(ack == 1, "R3 extra byte nack", ack, 1);
        bus_stop();
        chk(mode == 8'hA5, "R3 mode stored", mode, 8'hA5);

        // R2: foreign address
        bus_start();
        put_byte(8'h22, ack); chk(ack == 1, "R2 wrong write addr", ack, 1);
        put_byte(8'h00, ack); chk(ack == 1, "R2 byte after wrong addr", ack, 1);
        bus_stop();
        chk(mode == 8'hA5, "R2 mode kept", mode, 8'hA5);
        bus_start();
        put_byte(8'h23, ack); chk(ack == 1, "R2 wrong read addr", ack, 1);
        get_byte(v, 1); chk(v == 8'hFF, "R2 no drive", v, 8'hFF);
        bus_stop();

        // R1: sel high pair
        sel = 1;
        bus_start();
        put_byte(8'h22, ack); chk(ack == 0, "R1 write addr sel high", ack, 0);
        put_byte(8'h0B, ack); chk(ack == 0, "R1 control ack", ack, 0);
        bus_stop();
        chk(mode == 8'h0B, "R1 mode stored", mode, 8'h0B);

        // R5 R6 R10 R8: full read beyond end
        clr_before = clr_cnt;
        bus_start();
        data = ~data;  // R10 changes after START must not show
        put_byte(8'h23, ack); chk(ack == 0, "R1 read addr sel high", ack, 0);
        for (int k = 0; k < NB + 2; k++) begin
            get_byte(v, (k == NB + 1));
            if (k < NB) chk(v == model_byte(k), "R5 R10 byte", v, model_byte(k));
            else chk(v == 8'hFF, "R6 past end", v, 8'hFF);
        end
        get_byte(v, 1); chk(v == 8'hFF, "R8 released after nack", v, 8'hFF);
        bus_stop();
        chk(clr_cnt == clr_before + 1, "R8 one clear pulse", clr_cnt, clr_before + 1);
        chk(mode == 8'h0B, "R5 mode unaffected by read", mode, 8'h0B);

        // R7: repeated START restarts at byte 1 with a fresh snapshot
        clr_before = clr_cnt;
        bus_start();
        put_byte(8'h23, ack); chk(ack == 0, "R7 first read addr", ack, 0);
        get_byte(v, 0); chk(v == model_byte(0), "R7 byte1", v, model_byte(0));
        get_byte(v, 1); chk(v == model_byte(1), "R7 byte2", v, model_byte(1));
        data[7:0] = 8'h96;
        bus_start();
        put_byte(8'h23, ack); chk(ack == 0, "R7 repeated read addr", ack, 0);
        get_byte(v, 0); chk(v == 8'h96, "R7 R10 restart byte1", v, 8'h96);
        get_byte(v, 1); chk(v == model_byte(1), "R7 restart byte2", v, model_byte(1));
        bus_stop();
        chk(clr_cnt == clr_before + 2, "R8 clear per nack", clr_cnt, clr_before + 2);

        repeat (10) @(negedge clk);
        run_cmp = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule